// File: doc/BRIEF.md
# Command/Response FIFO Transfer Engine

This block carries one command from a host into a shared byte buffer, hands it to an external executor, and streams the executor's response back to the host. The host sees two registers. The first is a status word that holds flags, a burst count and a few write-one control bits. The second is a data FIFO port. A five-state controller decides what each access does. The states are idle, ready, receiving, executing and complete.

The engine learns the command length from the command's own header. It stops asking for bytes once the header's count is reached. The host then writes the go bit, and the engine pulses a start strobe towards the executor. The executor reads the command through a private buffer port and writes its response there. It then pulses done with the response length. The host reads the response back through the FIFO port, and it can rewind and read it again. Writing command-ready at any time brings the engine back to ready. If a command is still running, this first cancels it.

Top module: `cmd_rsp_engine`

## Requirements
- R1: The status control bits are bit 6 (command-ready), bit 5 (go) and bit 1 (retry). Writing command-ready has these effects by state. In idle, the engine enters ready with only the command-ready flag set. In ready, it only returns the buffer pointer to 0. In complete, it returns the pointer to 0, enters ready, sets command-ready and clears data-available.
- R2: In ready, the first FIFO write enters receiving and sets the status flags to expect plus valid. FIFO writes in idle, executing or complete store nothing and move neither the pointer nor the state.
- R3: The command length is a big-endian 32-bit value held in command bytes 2 to 5. Once more than 5 bytes are stored, expect (status bit 3) stays set while the stored count is below that length. It clears as soon as the count reaches the length. After that, further FIFO writes are dropped.
- R4: Writing go in receiving with expect clear enters executing. The next cycle then raises execStart for exactly one cycle, and execCmdLen gives the stored byte count. Go has no effect in any other state, or while expect is set.
- R5: On execDone in executing without an abort, the engine enters complete with status valid (bit 7) plus data-available (bit 4), and the pointer returns to 0. The response length is taken as the smaller of execRespLen and the buffer depth.
- R6: With data-available set, FIFO reads return successive response bytes. The access that consumes the last byte leaves only valid set. Any byte read with no data available returns 0xFF.
- R7: Writing retry in complete returns the pointer to 0 and sets valid plus data-available again. Retry is ignored in other states.
- R8: Status bits [23:8] hold the burst count. When data-available is set, this is the number of response bytes not yet read. Otherwise it is the free buffer space. A status read with a size code of 0 (one byte) limits the count to 255.
- R9: Status bit 2 (self-test-done) is set by execDone when execSelfTest is high. It stays set until reset, across all other status changes. Bits [27:26] always show the FAMILY parameter.
- R10: The size code means 0 = 1 byte, 1 = 2 bytes, and 2 or 3 = 4 bytes. A FIFO access moves the smaller of that size and 4 minus hostByteOff bytes. FIFO data is always low-aligned, so byte n of the access sits in bits [8n+7:8n]. Unused read lanes return 0.
- R11: Writing command-ready in receiving enters ready at once, with the pointer at 0 and only command-ready set. In executing, it raises execCancel for one cycle and stays in executing. The following execDone then enters ready with command-ready set, and the response is discarded.
- R12: FIFO bytes that would go past the buffer end are dropped. Such an overflow clears expect and leaves valid set.
- R13: A status write acts only when hostByteOff is 0 and exactly one of bits 6, 5 and 1 is set. Otherwise it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe (only FIFO reads have side effects) |
| hostSelFifo | input | 1 | 1 = data FIFO, 0 = status word |
| hostByteOff | input | 2 | Byte offset of the access within the 32-bit word |
| hostSize | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data, valid in the cycle of hostRdEn |
| execStart | output | 1 | One-cycle pulse: command ready for execution |
| execCancel | output | 1 | One-cycle pulse: running command aborted |
| execCmdLen | output | PW | Stored command byte count |
| execRdAddr | input | AW | Executor buffer read address |
| execRdData | output | 8 | Executor buffer read data |
| execWrEn | input | 1 | Executor buffer write strobe |
| execWrAddr | input | AW | Executor buffer write address |
| execWrData | input | 8 | Executor buffer write data |
| execDone | input | 1 | Executor finished pulse |
| execRespLen | input | 16 | Response length given with execDone |
| execSelfTest | input | 1 | Executor reports self-test finished, with execDone |

## Verification
Some properties are checked on every clock. Expect is only ever set while receiving, and data-available only while complete. Self-test-done never falls. Executing is entered only from receiving. The start strobe lasts a single cycle, and cancel is only raised while executing. The pointer never passes the buffer depth and always reaches 0 after a clear strobe. Other behaviour depends on the access sequence, so only the bench scenarios can show it. This includes the big-endian length decode across split and clipped writes, and the sequence of response bytes and 0xFF fill. It also includes the burst values and their byte-read limit, the retry rewind, and the aborted response being discarded.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READY,
    ST_RECV,
    ST_EXEC,
    ST_DONE
  } xferState_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic ptrZero;
    logic wrFifo;
    logic rdFifo;
    logic loadResp;
  } dpCtl_t;

endpackage

// File: rtl/xfer_data.sv
module xfer_data
  import xfer_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int PW = $clog2(DEPTH + 1),
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  dpCtl_t        ctl,
  input  logic [2:0]    accCnt,
  input  logic [31:0]   wrData,
  input  logic          byteRead,
  input  logic          dataAvail,
  input  logic [AW-1:0] execRdAddr,
  output logic [7:0]    execRdData,
  input  logic          execWrEn,
  input  logic [AW-1:0] execWrAddr,
  input  logic [7:0]    execWrData,
  input  logic [15:0]   execRespLen,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] ptrNextW,
  output logic [31:0]   lenNextW,
  output logic          wrOverflow,
  output logic          rdLast,
  output logic [31:0]   rdWord,
  output logic [15:0]   burst
);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] ptrQ, respLenQ;
  logic [31:0]   lenQ;
  logic [PW-1:0] cnt, space, stored, remain, consumed, rawBurst;

  assign cnt        = PW'(accCnt);
  assign space      = PW'(DEPTH) - ptrQ;
  assign wrOverflow = cnt > space;
  assign stored     = wrOverflow ? space : cnt;
  assign ptrNextW   = ptrQ + stored;
  assign remain     = respLenQ - ptrQ;
  assign consumed   = (cnt > remain) ? remain : cnt;
  assign rdLast     = cnt >= remain;
  assign ptr        = ptrQ;
  assign execRdData = mem[execRdAddr];

  // length field assembled from stored bytes plus the bytes of this write
  always_comb begin
    lenNextW = lenQ;
    for (int i = 0; i < 4; i++) begin
      if (PW'(i) < stored) begin
        if (ptrQ + PW'(i) == PW'(2)) lenNextW[31:24] = wrData[8*i +: 8];
        if (ptrQ + PW'(i) == PW'(3)) lenNextW[23:16] = wrData[8*i +: 8];
        if (ptrQ + PW'(i) == PW'(4)) lenNextW[15:8]  = wrData[8*i +: 8];
        if (ptrQ + PW'(i) == PW'(5)) lenNextW[7:0]   = wrData[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.wrFifo) begin
      for (int i = 0; i < 4; i++) begin
        if (PW'(i) < stored) mem[AW'(ptrQ + PW'(i))] <= wrData[8*i +: 8];
      end
    end else if (execWrEn) begin
      mem[execWrAddr] <= execWrData;
    end
  end

  always_comb begin
    rdWord = '0;
    for (int i = 0; i < 4; i++) begin
      if (PW'(i) < cnt) begin
        if (ctl.rdFifo && PW'(i) < remain) rdWord[8*i +: 8] = mem[AW'(ptrQ + PW'(i))];
        else rdWord[8*i +: 8] = 8'hFF;
      end
    end
  end

  assign rawBurst = dataAvail ? remain : space;
  assign burst    = (byteRead && rawBurst > PW'(255)) ? 16'd255 : 16'(rawBurst);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptrQ     <= '0;
      lenQ     <= '0;
      respLenQ <= '0;
    end else begin
      if (ctl.ptrZero) begin
        ptrQ <= '0;
        lenQ <= '0;
      end else if (ctl.wrFifo) begin
        ptrQ <= ptrNextW;
        lenQ <= lenNextW;
      end else if (ctl.rdFifo) begin
        ptrQ <= ptrQ + consumed;
      end
      if (ctl.loadResp)
        respLenQ <= (execRespLen > 16'(DEPTH)) ? PW'(DEPTH) : PW'(execRespLen);
    end
  end

  assert_ptr_bound_R12: assert property (@(posedge clk) disable iff (rst)
    ptrQ <= PW'(DEPTH));
  assert_ptr_clear_R1: assert property (@(posedge clk) disable iff (rst)
    ctl.ptrZero |=> ptrQ == '0);
  assert_read_inside_R6: assert property (@(posedge clk) disable iff (rst)
    ctl.rdFifo |=> ptrQ <= respLenQ);

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmdRdyWr,
  input  logic          goWr,
  input  logic          retryWr,
  input  logic          fifoWr,
  input  logic          fifoRd,
  input  logic [PW-1:0] ptrNextW,
  input  logic [31:0]   lenNextW,
  input  logic          wrOverflow,
  input  logic          rdLast,
  input  logic          execDone,
  input  logic          execSelfTest,
  output dpCtl_t        ctl,
  output xferState_t    state,
  output logic          cmdReady,
  output logic          expectMore,
  output logic          stsValid,
  output logic          dataAvail,
  output logic          selfTest,
  output logic          execStart,
  output logic          execCancel
);

  xferState_t stateQ, stateN;
  logic cmdRdyQ, cmdRdyN, expQ, expN, validQ, validN, availQ, availN;
  logic abortQ, abortN, startN, cancelN, selfQ, expectCalc;

  always_comb begin
    if (wrOverflow) expectCalc = 1'b0;
    else if (ptrNextW > PW'(5)) expectCalc = lenNextW > 32'(ptrNextW);
    else expectCalc = 1'b1;
  end

  always_comb begin
    stateN  = stateQ;
    cmdRdyN = cmdRdyQ;
    expN    = expQ;
    validN  = validQ;
    availN  = availQ;
    abortN  = abortQ;
    startN  = 1'b0;
    cancelN = 1'b0;
    ctl     = '0;
    case (stateQ)
      ST_IDLE: begin
        if (cmdRdyWr) begin
          stateN = ST_READY;
          ctl.ptrZero = 1'b1;
          {cmdRdyN, expN, validN, availN} = 4'b1000;
        end
      end
      ST_READY: begin
        if (cmdRdyWr) begin
          ctl.ptrZero = 1'b1;
        end else if (fifoWr) begin
          stateN = ST_RECV;
          ctl.wrFifo = 1'b1;
          {cmdRdyN, expN, validN, availN} = {1'b0, expectCalc, 2'b10};
        end
      end
      ST_RECV: begin
        if (cmdRdyWr) begin
          stateN = ST_READY;
          ctl.ptrZero = 1'b1;
          {cmdRdyN, expN, validN, availN} = 4'b1000;
        end else if (goWr && !expQ) begin
          stateN = ST_EXEC;
          startN = 1'b1;
        end else if (fifoWr && expQ) begin
          ctl.wrFifo = 1'b1;
          {cmdRdyN, expN, validN, availN} = {1'b0, expectCalc, 2'b10};
        end
      end
      ST_EXEC: begin
        if (execDone) begin
          ctl.ptrZero = 1'b1;
          abortN = 1'b0;
          if (abortQ) begin
            stateN = ST_READY;
            {cmdRdyN, expN, validN, availN} = 4'b1000;
          end else begin
            stateN = ST_DONE;
            ctl.loadResp = 1'b1;
            {cmdRdyN, expN, validN, availN} = 4'b0011;
          end
        end else if (cmdRdyWr && !abortQ) begin
          abortN  = 1'b1;
          cancelN = 1'b1;
        end
      end
      ST_DONE: begin
        if (cmdRdyWr) begin
          stateN = ST_READY;
          ctl.ptrZero = 1'b1;
          {cmdRdyN, expN, validN, availN} = 4'b1000;
        end else if (retryWr) begin
          ctl.ptrZero = 1'b1;
          {cmdRdyN, expN, validN, availN} = 4'b0011;
        end else if (fifoRd && availQ) begin
          ctl.rdFifo = 1'b1;
          if (rdLast) {cmdRdyN, expN, validN, availN} = 4'b0010;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ     <= ST_IDLE;
      cmdRdyQ    <= 1'b0;
      expQ       <= 1'b0;
      validQ     <= 1'b0;
      availQ     <= 1'b0;
      abortQ     <= 1'b0;
      selfQ      <= 1'b0;
      execStart  <= 1'b0;
      execCancel <= 1'b0;
    end else begin
      stateQ     <= stateN;
      cmdRdyQ    <= cmdRdyN;
      expQ       <= expN;
      validQ     <= validN;
      availQ     <= availN;
      abortQ     <= abortN;
      execStart  <= startN;
      execCancel <= cancelN;
      if (stateQ == ST_EXEC && execDone && execSelfTest) selfQ <= 1'b1;
    end
  end

  assign state      = stateQ;
  assign cmdReady   = cmdRdyQ;
  assign expectMore = expQ;
  assign stsValid   = validQ;
  assign dataAvail  = availQ;
  assign selfTest   = selfQ;

  assert_expect_recv_R3: assert property (@(posedge clk) disable iff (rst)
    expQ |-> stateQ == ST_RECV);
  assert_avail_done_R5: assert property (@(posedge clk) disable iff (rst)
    availQ |-> stateQ == ST_DONE);
  assert_selftest_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    selfQ |=> selfQ);
  assert_exec_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_EXEC && $past(stateQ) != ST_EXEC) |-> $past(stateQ) == ST_RECV);
  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    execStart |=> !execStart);
  assert_cancel_exec_R11: assert property (@(posedge clk) disable iff (rst)
    execCancel |-> stateQ == ST_EXEC);

endmodule

// File: rtl/cmd_rsp_engine.sv
module cmd_rsp_engine
  import xfer_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter logic [1:0] FAMILY = 2'b10,
  parameter int PW = $clog2(DEPTH + 1),
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hostWrEn,
  input  logic          hostRdEn,
  input  logic          hostSelFifo,
  input  logic [1:0]    hostByteOff,
  input  logic [1:0]    hostSize,
  input  logic [31:0]   hostWrData,
  output logic [31:0]   hostRdData,
  output logic          execStart,
  output logic          execCancel,
  output logic [PW-1:0] execCmdLen,
  input  logic [AW-1:0] execRdAddr,
  output logic [7:0]    execRdData,
  input  logic          execWrEn,
  input  logic [AW-1:0] execWrAddr,
  input  logic [7:0]    execWrData,
  input  logic          execDone,
  input  logic [15:0]   execRespLen,
  input  logic          execSelfTest
);

  dpCtl_t        ctl;
  xferState_t    state;
  logic          cmdReady, expectMore, stsValid, dataAvail, selfTest;
  logic [PW-1:0] ptr, ptrNextW;
  logic [31:0]   lenNextW, rdWord, stsWord;
  logic          wrOverflow, rdLast, stsWr;
  logic [2:0]    sizeBytes, room, accCnt;
  logic [15:0]   burst;

  always_comb begin
    case (hostSize)
      2'd0:    sizeBytes = 3'd1;
      2'd1:    sizeBytes = 3'd2;
      default: sizeBytes = 3'd4;
    endcase
  end
  assign room   = 3'd4 - {1'b0, hostByteOff};
  assign accCnt = (sizeBytes > room) ? room : sizeBytes;
  assign stsWr  = hostWrEn && !hostSelFifo && hostByteOff == 2'd0;

  xfer_ctrl #(.PW(PW)) uCtrl (
    .clk(clk), .rst(rst),
    .cmdRdyWr(stsWr && hostWrData[6] && !hostWrData[5] && !hostWrData[1]),
    .goWr    (stsWr && !hostWrData[6] && hostWrData[5] && !hostWrData[1]),
    .retryWr (stsWr && !hostWrData[6] && !hostWrData[5] && hostWrData[1]),
    .fifoWr(hostWrEn && hostSelFifo),
    .fifoRd(hostRdEn && hostSelFifo && !hostWrEn),
    .ptrNextW(ptrNextW), .lenNextW(lenNextW), .wrOverflow(wrOverflow), .rdLast(rdLast),
    .execDone(execDone), .execSelfTest(execSelfTest),
    .ctl(ctl), .state(state), .cmdReady(cmdReady), .expectMore(expectMore),
    .stsValid(stsValid), .dataAvail(dataAvail), .selfTest(selfTest),
    .execStart(execStart), .execCancel(execCancel)
  );

  xfer_data #(.DEPTH(DEPTH), .PW(PW), .AW(AW)) uData (
    .clk(clk), .rst(rst), .ctl(ctl), .accCnt(accCnt), .wrData(hostWrData),
    .byteRead(hostSize == 2'd0), .dataAvail(dataAvail),
    .execRdAddr(execRdAddr), .execRdData(execRdData),
    .execWrEn(execWrEn), .execWrAddr(execWrAddr), .execWrData(execWrData),
    .execRespLen(execRespLen),
    .ptr(ptr), .ptrNextW(ptrNextW), .lenNextW(lenNextW), .wrOverflow(wrOverflow),
    .rdLast(rdLast), .rdWord(rdWord), .burst(burst)
  );

  assign stsWord = {4'b0, FAMILY, 2'b00, burst, stsValid, cmdReady, 1'b0,
                    dataAvail, expectMore, selfTest, 2'b00};
  assign hostRdData = hostSelFifo ? rdWord : stsWord;
  assign execCmdLen = ptr;

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (rst)
    state inside {ST_IDLE, ST_READY, ST_RECV, ST_EXEC, ST_DONE});

endmodule

// File: tb/tb_cmd_rsp_engine.sv
module tb_cmd_rsp_engine;

  localparam int DEPTH = 512;
  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hostWrEn = 0, hostRdEn = 0, hostSelFifo = 0;
  logic [1:0] hostByteOff = 0, hostSize = 0;
  logic [31:0] hostWrData = 0, hostRdData;
  logic execStart, execCancel;
  logic [PW-1:0] execCmdLen;
  logic [AW-1:0] execRdAddr = 0, execWrAddr = 0;
  logic [7:0] execRdData, execWrData = 0;
  logic execWrEn = 0, execDone = 0, execSelfTest = 0;
  logic [15:0] execRespLen = 0;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  cmd_rsp_engine dut (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostSelFifo(hostSelFifo), .hostByteOff(hostByteOff), .hostSize(hostSize),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .execStart(execStart), .execCancel(execCancel), .execCmdLen(execCmdLen),
    .execRdAddr(execRdAddr), .execRdData(execRdData), .execWrEn(execWrEn),
    .execWrAddr(execWrAddr), .execWrData(execWrData), .execDone(execDone),
    .execRespLen(execRespLen), .execSelfTest(execSelfTest)
  );

  function automatic logic [31:0] sw(input logic [7:0] flags, input logic [15:0] bc);
    return {4'b0, 2'b10, 2'b00, bc, flags};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWr(input logic sel, input logic [1:0] off, input logic [1:0] sz,
                        input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1; hostSelFifo = sel; hostByteOff = off; hostSize = sz; hostWrData = d;
    @(posedge clk); #1;
    hostWrEn = 0;
  endtask

  task automatic hostRd(input logic sel, input logic [1:0] off, input logic [1:0] sz,
                        output logic [31:0] d);
    @(negedge clk);
    hostRdEn = 1; hostSelFifo = sel; hostByteOff = off; hostSize = sz;
    #1 d = hostRdData;
    @(posedge clk); #1;
    hostRdEn = 0;
  endtask

  task automatic stsRd(output logic [31:0] d);
    hostRd(1'b0, 2'd0, 2'd2, d);
  endtask

  task automatic finishExec(input logic [15:0] len, input logic st);
    @(negedge clk);
    execDone = 1; execRespLen = len; execSelfTest = st;
    @(posedge clk); #1;
    execDone = 0; execSelfTest = 0;
  endtask

  task automatic testReset();
    stsRd(rd);
    chk("R8 reset status word", rd, sw(8'h00, 16'd512));
    hostRd(1'b0, 2'd0, 2'd0, rd);
    chk("R8 byte status read saturates", rd, sw(8'h00, 16'd255));
  endtask

  task automatic testIdle();
    hostWr(1'b1, 2'd0, 2'd2, 32'h11223344);
    stsRd(rd);
    chk("R2 FIFO write in idle dropped", rd, sw(8'h00, 16'd512));
    hostWr(1'b0, 2'd0, 2'd0, 32'h20);
    stsRd(rd);
    chk("R4 go ignored in idle", rd, sw(8'h00, 16'd512));
    hostWr(1'b0, 2'd1, 2'd0, 32'h40);
    stsRd(rd);
    chk("R13 status write at nonzero offset ignored", rd, sw(8'h00, 16'd512));
    hostWr(1'b0, 2'd0, 2'd0, 32'h40);
    stsRd(rd);
    chk("R1 idle to ready sets command-ready", rd, sw(8'h40, 16'd512));
  endtask

  task automatic testCommand();
    hostWr(1'b1, 2'd0, 2'd2, 32'h00000180);
    stsRd(rd);
    chk("R2 first write enters receiving", rd, sw(8'h88, 16'd508));
    hostWr(1'b1, 2'd0, 2'd1, 32'h00000A00);
    stsRd(rd);
    chk("R3 six bytes, length 10 still expected", rd, sw(8'h88, 16'd506));
    hostWr(1'b1, 2'd2, 2'd2, 32'hEEEE2211);
    stsRd(rd);
    chk("R10 clipped access moves two bytes", rd, sw(8'h88, 16'd504));
    hostWr(1'b1, 2'd0, 2'd0, 32'h00000033);
    hostWr(1'b0, 2'd0, 2'd0, 32'h20);
    stsRd(rd);
    chk("R4 go ignored while expect set", rd, sw(8'h88, 16'd503));
    hostWr(1'b1, 2'd0, 2'd0, 32'h00000044);
    stsRd(rd);
    chk("R3 expect clears at length", rd, sw(8'h80, 16'd502));
    hostWr(1'b1, 2'd0, 2'd0, 32'h00000055);
    stsRd(rd);
    chk("R3 write after complete frame dropped", rd, sw(8'h80, 16'd502));
    hostWr(1'b0, 2'd0, 2'd0, 32'h20);
    chk("R4 execStart pulse", {31'b0, execStart}, 32'd1);
    chk("R4 execCmdLen", 32'(execCmdLen), 32'd10);
    @(posedge clk); #1;
    chk("R4 execStart single cycle", {31'b0, execStart}, 32'd0);
    @(negedge clk); execRdAddr = 9'd5; #1;
    chk("R3 length byte in buffer", 32'(execRdData), 32'h0A);
    execRdAddr = 9'd7; #1;
    chk("R10 clipped bytes stored low-aligned", 32'(execRdData), 32'h22);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      execWrEn = 1; execWrAddr = AW'(k); execWrData = 8'hA0 + 8'(k);
      @(posedge clk); #1;
      execWrEn = 0;
    end
    finishExec(16'd6, 1'b1);
    stsRd(rd);
    chk("R5 completion status", rd, sw(8'h94, 16'd6));
  endtask

  task automatic testResponse();
    hostRd(1'b1, 2'd0, 2'd2, rd);
    chk("R6 first response word", rd, 32'hA3A2A1A0);
    stsRd(rd);
    chk("R8 burst shows remaining bytes", rd, sw(8'h94, 16'd2));
    hostRd(1'b1, 2'd0, 2'd2, rd);
    chk("R6 last bytes then 0xFF fill", rd, 32'hFFFFA5A4);
    stsRd(rd);
    chk("R6 only valid after last byte", rd, sw(8'h84, 16'd506));
    hostRd(1'b1, 2'd0, 2'd0, rd);
    chk("R6 read with no data gives 0xFF", rd, 32'h000000FF);
    hostWr(1'b0, 2'd0, 2'd0, 32'h02);
    stsRd(rd);
    chk("R7 retry restores data-available", rd, sw(8'h94, 16'd6));
    hostRd(1'b1, 2'd0, 2'd1, rd);
    chk("R7 retry rewinds pointer", rd, 32'h0000A1A0);
    hostWr(1'b1, 2'd0, 2'd2, 32'h99999999);
    hostRd(1'b1, 2'd0, 2'd0, rd);
    chk("R2 write in complete dropped", rd, 32'h000000A2);
    hostWr(1'b0, 2'd0, 2'd0, 32'h42);
    stsRd(rd);
    chk("R13 two control bits ignored", rd, sw(8'h94, 16'd3));
    hostWr(1'b0, 2'd0, 2'd0, 32'h40);
    stsRd(rd);
    chk("R1 complete to ready, self-test kept R9", rd, sw(8'h44, 16'd512));
  endtask

  task automatic testAbortRecv();
    hostWr(1'b1, 2'd0, 2'd2, 32'h01020304);
    hostWr(1'b0, 2'd0, 2'd0, 32'h40);
    stsRd(rd);
    chk("R11 abort in receiving", rd, sw(8'h44, 16'd512));
  endtask

  task automatic testAbortExec();
    hostWr(1'b1, 2'd0, 2'd2, 32'h00000000);
    hostWr(1'b1, 2'd0, 2'd1, 32'h00000600);
    hostWr(1'b0, 2'd0, 2'd0, 32'h20);
    hostWr(1'b0, 2'd0, 2'd0, 32'h40);
    chk("R11 execCancel pulse", {31'b0, execCancel}, 32'd1);
    stsRd(rd);
    chk("R11 stays executing until done", rd, sw(8'h84, 16'd506));
    finishExec(16'd3, 1'b0);
    stsRd(rd);
    chk("R11 aborted done returns to ready", rd, sw(8'h44, 16'd512));
    hostRd(1'b1, 2'd0, 2'd0, rd);
    chk("R11 aborted response discarded", rd, 32'h000000FF);
  endtask

  task automatic testOverflow();
    hostWr(1'b1, 2'd0, 2'd2, 32'h00000000);
    hostWr(1'b1, 2'd0, 2'd2, 32'h00000010);
    for (int k = 0; k < 126; k++) hostWr(1'b1, 2'd0, 2'd2, 32'h5A5A5A5A);
    stsRd(rd);
    chk("R12 full buffer still expecting", rd, sw(8'h8C, 16'd0));
    hostWr(1'b1, 2'd0, 2'd2, 32'h5A5A5A5A);
    stsRd(rd);
    chk("R12 overflow clears expect", rd, sw(8'h84, 16'd0));
    hostWr(1'b0, 2'd0, 2'd0, 32'h20);
    chk("R4 execCmdLen at full buffer", 32'(execCmdLen), 32'd512);
    finishExec(16'd700, 1'b0);
    stsRd(rd);
    chk("R5 response length clipped to depth", rd, sw(8'h94, 16'd512));
    hostRd(1'b0, 2'd0, 2'd0, rd);
    chk("R8 byte read burst saturates", rd, sw(8'h94, 16'd255));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R4 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    testReset();
    testIdle();
    testCommand();
    testResponse();
    testAbortRecv();
    testAbortExec();
    testOverflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule